// File: doc/BRIEF.md
# Dual-Sequence Binary-to-Thermometer Decoder

This block turns a 4-bit binary code into 15 unary outputs of equal weight. Each output drives one unit element of the most-significant segment of a current-steering converter. The elements sit on a 4x4 cell matrix. The decoder can switch them on in two different orders, so after measurement the system can pick whichever order lets the element mismatches cancel better. Choosing the order is a job for the surrounding system and is not part of this block.

Decoding takes two levels. In the first level, two small thermometer decoders expand the upper and lower 2-bit fields of the code. The upper field, code[3:2], is the "major" field and the lower field, code[1:0], is the "minor" field. A configuration bit routes these into column signals, row signals and their auxiliary copies. In the second level, every matrix position holds an identical symmetric OR-OR-AND cell. With row-first ordering selected, the cells act as a row-column decoder. With column-first ordering selected, the same cells act as a column-row decoder. The matrix has sixteen positions but there are only fifteen outputs. The spare position is ORed into output bit 2.

The order select is captured into a configuration register. The thermometer word is registered, so all fifteen outputs change together on a clock edge.

Top module: `btm_dual_seq_decoder`

## Requirements
- R1: While reset is asserted, and on the first sample after reset, thermOut is all zeros.
- R2: Code 0 gives thermOut all zeros in both orderings.
- R3: Code 15 gives thermOut all ones in both orderings.
- R4: The number of high bits in thermOut always equals the code that was registered.
- R5: With modeSel = 0 (row-first), output bit k is high if and only if k < code. This fills the matrix along rows, with bit k at row k/4, column k%4.
- R6: With modeSel = 1 (column-first), output bit k (row i = k/4, column j = k%4) is high if and only if j < code[3:2], or j == code[3:2] and i < code[1:0]. This fills the matrix down columns.
- R7: In each ordering, a bit that is high for code n stays high for every code greater than n.
- R8: thermOut takes the value for a new code on the first rising edge after the code is applied. It does not change between edges, and it stays stable while the code and the ordering are held.
- R9: The spare sixteenth matrix position never turns on, so output bit 2 depends only on its own cell.
- R10: A change of modeSel first reaches thermOut on the second rising edge after the change. The first edge still decodes with the previous ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 1 | Ordering select: 0 = row-first, 1 = column-first |
| codeIn | input | 4 | Binary code; [3:2] is the major field and [1:0] the minor field |
| thermOut | output | 15 | Registered thermometer word, one bit per unit element |

## Verification
The assertions assume that codeIn and modeSel are stable and known at each rising edge. They also assume that modeSel is treated as a static setting, changed only rarely with idle cycles around each change. The stimulus respects this by driving every input on the falling edge. After each change of ordering it waits two edges before sweeping codes. It then steps through all sixteen codes in each ordering, in rising order, so that the monotonic check compares neighbouring codes.

// File: rtl/btm_pkg.sv
package btm_pkg;

  // Element ordering chosen by the configuration bit
  typedef enum logic {
    SEQ_ROW_FIRST = 1'b0,
    SEQ_COL_FIRST = 1'b1
  } seq_mode_e;

  // Strobes from control to datapath that steer the first-level routing
  typedef struct packed {
    logic rowFirst;
    logic colFirst;
  } route_t;

endpackage

// File: rtl/btm_field_dec.sv
// First-level field decoder: expands a binary field into a thermometer word.
// INCLUSIVE = 1 gives bit k = (k <= field); INCLUSIVE = 0 gives bit k = (k < field).
module btm_field_dec #(
  parameter int W         = 2,
  parameter bit INCLUSIVE = 1'b1,
  localparam int N        = 1 << W
) (
  input  logic [W-1:0] field,
  output logic [N-1:0] therm
);

  for (genvar k = 0; k < N; k++) begin : g_bit
    if (INCLUSIVE) begin : g_inc
      assign therm[k] = (field >= W'(k));
    end else begin : g_str
      assign therm[k] = (field > W'(k));
    end
  end

endmodule

// File: rtl/btm_cell.sv
// Second-level symmetric cell: (col OR rowAux) AND (colAux OR row)
module btm_cell (
  input  logic colT,
  input  logic rowAux,
  input  logic colAux,
  input  logic rowT,
  output logic on
);

  logic leftTerm;
  logic rightTerm;

  assign leftTerm  = colT | rowAux;
  assign rightTerm = colAux | rowT;
  assign on        = leftTerm & rightTerm;

endmodule

// File: rtl/btm_ctrl.sv
// Control: holds the ordering as a static configuration value and issues routing strobes.
module btm_ctrl
  import btm_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   modeSel,
  output route_t route
);

  seq_mode_e modeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= SEQ_ROW_FIRST;
    end else begin
      modeQ <= seq_mode_e'(modeSel);
    end
  end

  always_comb begin
    route          = '0;
    route.rowFirst = (modeQ == SEQ_ROW_FIRST);
    route.colFirst = (modeQ == SEQ_COL_FIRST);
  end

  // R5 / R6: exactly one ordering is steering the matrix
  p_route_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones({route.rowFirst, route.colFirst}) == 1);

  // R10: the strobes only change one edge after modeSel changes
  p_mode_lag_r10: assert property (@(posedge clk) disable iff (!rstN)
    $stable(modeSel) |=> $stable(route));

endmodule

// File: rtl/btm_datapath.sv
// Datapath: first-level decoders, mode routing, cell matrix, spare merge, output register.
module btm_datapath
  import btm_pkg::*;
#(
  parameter int SIDE_BITS = 2,
  parameter int MERGE_IDX = 2,
  localparam int SIDE     = 1 << SIDE_BITS,
  localparam int CELLS    = SIDE * SIDE,
  localparam int OUT_W    = CELLS - 1,
  localparam int SPARE    = CELLS - 1,
  localparam int CODE_W   = 2 * SIDE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] codeIn,
  input  route_t            route,
  output logic [OUT_W-1:0]  thermOut
);

  logic [SIDE_BITS-1:0] majorField;
  logic [SIDE_BITS-1:0] minorField;
  logic [SIDE-1:0]      majorInc;   // bit k = (k <= major)
  logic [SIDE-1:0]      minorStr;   // bit k = (k <  minor)
  logic [SIDE-1:0]      xT;         // column signals
  logic [SIDE-1:0]      yT;         // row signals
  logic [SIDE:0]        xaExt;      // column aux, top entry is the boundary constant 0
  logic [SIDE:0]        yaExt;      // row aux, top entry is the boundary constant 0
  logic [CELLS-1:0]     cellOn;
  logic [OUT_W-1:0]     thermNext;
  logic                 primed;

  assign majorField = codeIn[CODE_W-1:SIDE_BITS];
  assign minorField = codeIn[SIDE_BITS-1:0];

  // First level
  btm_field_dec #(.W(SIDE_BITS), .INCLUSIVE(1'b1)) u_major_dec (
    .field (majorField),
    .therm (majorInc)
  );

  btm_field_dec #(.W(SIDE_BITS), .INCLUSIVE(1'b0)) u_minor_dec (
    .field (minorField),
    .therm (minorStr)
  );

  // Routing: row-first puts the major field on rows; column-first on columns.
  always_comb begin
    xT    = route.colFirst ? majorInc : minorStr;
    yT    = route.colFirst ? minorStr : majorInc;
    xaExt = {1'b0, (route.colFirst ? xT : {SIDE{1'b0}})};
    yaExt = {1'b0, (route.rowFirst ? yT : {SIDE{1'b0}})};
  end

  // Second level: identical symmetric cells
  for (genvar i = 0; i < SIDE; i++) begin : g_row
    for (genvar j = 0; j < SIDE; j++) begin : g_col
      btm_cell u_cell (
        .colT   (xT[j]),
        .rowAux (yaExt[i+1]),
        .colAux (xaExt[j+1]),
        .rowT   (yT[i]),
        .on     (cellOn[i*SIDE+j])
      );
    end
  end

  // Spare position folded into one output
  always_comb begin
    thermNext            = cellOn[OUT_W-1:0];
    thermNext[MERGE_IDX] = cellOn[MERGE_IDX] | cellOn[SPARE];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thermOut <= '0;
      primed   <= 1'b0;
    end else begin
      thermOut <= thermNext;
      primed   <= 1'b1;
    end
  end

  p_spare_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !cellOn[SPARE]);

  p_zero_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    (codeIn == '0) |=> (thermOut == '0));

  p_full_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    (codeIn == {CODE_W{1'b1}}) |=> (thermOut == {OUT_W{1'b1}}));

  p_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ($countones(thermOut) == int'($past(codeIn))));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $stable(codeIn) && $stable(route)) |=> $stable(thermOut));

endmodule

// File: rtl/btm_dual_seq_decoder.sv
// Top: binary-to-thermometer decoder with two selectable element orderings.
module btm_dual_seq_decoder
  import btm_pkg::*;
#(
  parameter int SIDE_BITS = 2,
  parameter int MERGE_IDX = 2,
  localparam int CODE_W   = 2 * SIDE_BITS,
  localparam int OUT_W    = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSel,
  input  logic [CODE_W-1:0] codeIn,
  output logic [OUT_W-1:0]  thermOut
);

  route_t route;

  btm_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .route   (route)
  );

  btm_datapath #(
    .SIDE_BITS (SIDE_BITS),
    .MERGE_IDX (MERGE_IDX)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .codeIn   (codeIn),
    .route    (route),
    .thermOut (thermOut)
  );

endmodule

// File: tb/btm_dual_seq_decoder_tb.sv
module btm_dual_seq_decoder_tb;

  logic        clk;
  logic        rstN;
  logic        modeSel;
  logic [3:0]  codeIn;
  logic [14:0] thermOut;

  int checks;
  int fails;
  bit done;

  btm_dual_seq_decoder u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .codeIn   (codeIn),
    .thermOut (thermOut)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Expected pattern from the ordering rules of R5 and R6
  function automatic logic [14:0] expPat(input int mode, input int n);
    logic [14:0] p;
    int r;
    int c;
    p = '0;
    r = n / 4;
    c = n % 4;
    for (int k = 0; k < 15; k++) begin
      if (mode == 0) p[k] = (k < n);
      else p[k] = ((k % 4) < r) || (((k % 4) == r) && ((k / 4) < c));
    end
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input logic [14:0] act,
                       input logic [14:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic applyCode(input int n);
    @(negedge clk);
    codeIn = 4'(n);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setMode(input bit m);
    @(negedge clk);
    modeSel = m;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [14:0] prev;
    logic [14:0] exp;
    checks  = 0;
    fails   = 0;
    done    = 0;
    rstN    = 1'b0;
    modeSel = 1'b0;
    codeIn  = 4'd9;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(thermOut == '0, "R1 in reset", thermOut, 15'h0);
    rstN = 1'b1;
    #1;
    check(thermOut == '0, "R1 after release", thermOut, 15'h0);

    for (int m = 0; m < 2; m++) begin
      setMode(m[0]);
      prev = '0;
      for (int n = 0; n < 16; n++) begin
        applyCode(n);
        exp = expPat(m, n);
        if (m == 0) check(thermOut == exp, "R5 row-first pattern", thermOut, exp);
        else check(thermOut == exp, "R6 column-first pattern (R9 bit 2)", thermOut, exp);
        check($countones(thermOut) == n, "R4 popcount", thermOut, exp);
        check((prev & ~thermOut) == '0, "R7 monotonic", thermOut, prev | thermOut);
        if (n == 0) check(thermOut == '0, "R2 zero code", thermOut, 15'h0);
        if (n == 15) check(thermOut == 15'h7fff, "R3 full code", thermOut, 15'h7fff);
        prev = thermOut;
      end
    end

    // R8: latency of one edge, no change between edges, holds while stable
    applyCode(9);
    exp = expPat(1, 9);
    @(negedge clk);
    codeIn = 4'd6;
    #2;
    check(thermOut == exp, "R8 no change before edge", thermOut, exp);
    @(posedge clk);
    @(negedge clk);
    exp = expPat(1, 6);
    check(thermOut == exp, "R8 updates on first edge", thermOut, exp);
    repeat (3) @(negedge clk);
    check(thermOut == exp, "R8 holds while stable", thermOut, exp);

    // R10: ordering change appears on the second edge
    applyCode(5);
    @(negedge clk);
    modeSel = 1'b0;
    @(posedge clk);
    @(negedge clk);
    exp = expPat(1, 5);
    check(thermOut == exp, "R10 first edge keeps old ordering", thermOut, exp);
    @(posedge clk);
    @(negedge clk);
    exp = expPat(0, 5);
    check(thermOut == exp, "R10 second edge uses new ordering", thermOut, exp);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule